// File: doc/BRIEF.md
# FIFO Status Channel Generator

This block turns a parallel set of per-port FIFO fill codes into a serial, framed status stream on a two-bit bus. While enabled it loops forever over a fixed calendar. Each frame opens with the reserved all-ones framing word. One status word per port follows, starting at port 0, one port per clock. If parity is turned on, the frame then ends with a two-bit diagonal odd-parity (DIP-2) word. The receiving side uses the framing word to find the start of each frame and the parity word to check the words it received.

The port codes are sampled once, on the clock that emits the framing word, so every word in a frame comes from the same snapshot. The framing word is excluded from the parity. Parity starts from zero at each frame. Each port word is folded in by swapping the two accumulator bits and then XORing in the word. A placeholder all-ones word is folded in last, and the result is inverted.

The output is a continuous, free-running bus with no handshake and no back-pressure. A receiver must accept one word on every clock. All controls are plain level inputs.

Top module: `fsc_gen`

## Requirements
- R1: While rst_n is low, and on every clock after one on which en was sampled low, stat is 2'b11. The output is registered: a word chosen at a clock edge appears right after that edge.
- R2: Once en is sampled high, stat first carries the framing word 2'b11. It then carries the NPORTS port words on consecutive clocks, in order from port 0 to port NPORTS-1. Port i's word is port_stat[2i+1:2i], with bit 2i+1 on stat[1].
- R3: A port whose input code is 2'b11 is sent as 2'b10. A port word is never 2'b11.
- R4: port_stat is captured on the clock edge that emits the framing word. Changes to port_stat after that edge do not affect the rest of the frame.
- R5: If dip_en is high on the edge that emits the last port word, the next word is the DIP-2 word. It is computed as follows: start with a=00; for each port word w as sent, a={a[0],a[1]}^w; then fold in 2'b11 the same way; the DIP-2 word is the bitwise inverse of the result.
- R6: If dip_en is low on the edge that emits the last port word, the next word is the framing word.
- R7: While en stays high, frames follow one another with no gap, and each frame takes a new snapshot.
- R8: If en drops in the middle of a frame, that frame is abandoned and stat becomes 2'b11 from the next clock. When en is raised again, a complete new frame starts, with a new snapshot and the parity restarted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the status calendar; low forces framing/idle |
| dip_en | input | 1 | Append the parity word to each frame |
| port_stat | input | 2*NPORTS | Status code per port, port i in bits [2i+1:2i] |
| stat | output | 2 | Serial status bus |

## Verification
On every cycle, the assertions check the shape of the frame:
- the idle value while disabled;
- that the framing word leads into port 0;
- that port indices step by one with no word equal to 2'b11;
- that the slot after the last port follows dip_en;
- that the parity slot is followed by framing.

Only the bench's scenarios can show that the data is right. A scoreboard compares each word against a model. The scenarios cover:
- mixed codes and reserved input codes;
- port_stat changing in the middle of a frame;
- frames with and without parity, back to back;
- a frame abandoned by dropping en and then restarted.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam logic [1:0] FRAME_CODE = 2'b11;
  localparam logic [1:0] SUBST_CODE = 2'b10;

  typedef enum logic [1:0] {
    SLOT_FRAME = 2'd0,
    SLOT_PORT  = 2'd1,
    SLOT_DIP   = 2'd2
  } slot_e;

  // one diagonal step: rotate the two lanes, then add the new word
  function automatic logic [1:0] dip_fold(input logic [1:0] acc, input logic [1:0] w);
    return {acc[0], acc[1]} ^ w;
  endfunction
endpackage

// File: rtl/fsc_sequencer.sv
module fsc_sequencer
  import fsc_pkg::*;
#(
  parameter int NPORTS = 10,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dip_en,
  output slot_e            kind,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPORTS - 1);

  slot_e            kind_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SLOT_FRAME;
      idx_q  <= '0;
    end else if (!en) begin
      kind_q <= SLOT_FRAME;
      idx_q  <= '0;
    end else begin
      case (kind_q)
        SLOT_FRAME: begin
          kind_q <= SLOT_PORT;
          idx_q  <= '0;
        end
        SLOT_PORT: begin
          if (idx_q == LAST) begin
            kind_q <= dip_en ? SLOT_DIP : SLOT_FRAME;
            idx_q  <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: begin
          kind_q <= SLOT_FRAME;
          idx_q  <= '0;
        end
      endcase
    end
  end

  assign kind = kind_q;
  assign idx  = idx_q;
endmodule

// File: rtl/fsc_parity.sv
module fsc_parity
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic [1:0] word,
  output logic [1:0] dip
);
  logic [1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= 2'b00;
    else if (clear) acc_q <= 2'b00;
    else if (load)  acc_q <= dip_fold(acc_q, word);
  end

  // placeholder all-ones word folded in, then inverted for odd parity
  assign dip = ~dip_fold(acc_q, FRAME_CODE);
endmodule

// File: rtl/fsc_gen.sv
module fsc_gen
  import fsc_pkg::*;
#(
  parameter int NPORTS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                dip_en,
  input  logic [2*NPORTS-1:0] port_stat,
  output logic [1:0]          stat
);
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  slot_e               kind;
  logic [IDX_W-1:0]    idx;
  logic [2*NPORTS-1:0] clean;
  logic [2*NPORTS-1:0] snap_q;
  logic [1:0]          port_word;
  logic [1:0]          dip;
  logic [1:0]          next_word;
  logic [1:0]          stat_q;

  fsc_sequencer #(.NPORTS(NPORTS), .IDX_W(IDX_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .dip_en(dip_en),
    .kind(kind), .idx(idx)
  );

  // the reserved code never leaves as a port word
  for (genvar p = 0; p < NPORTS; p++) begin : g_clean
    assign clean[2*p +: 2] = (port_stat[2*p +: 2] == FRAME_CODE) ? SUBST_CODE
                                                                : port_stat[2*p +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          snap_q <= '0;
    else if (en && kind == SLOT_FRAME)   snap_q <= clean;
  end

  assign port_word = snap_q[2*idx +: 2];

  fsc_parity i_par (
    .clk(clk), .rst_n(rst_n),
    .clear(kind == SLOT_FRAME),
    .load(en && kind == SLOT_PORT),
    .word(port_word),
    .dip(dip)
  );

  always_comb begin
    next_word = FRAME_CODE;
    if (en) begin
      case (kind)
        SLOT_PORT: next_word = port_word;
        SLOT_DIP:  next_word = dip;
        default:   next_word = FRAME_CODE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= FRAME_CODE;
    else        stat_q <= next_word;
  end

  assign stat = stat_q;
endmodule

// File: rtl/fsc_gen_chk.sv
module fsc_gen_chk
  import fsc_pkg::*;
#(
  parameter int NPORTS = 10,
  parameter int IDX_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dip_en,
  input logic [1:0]       stat,
  input slot_e            kind,
  input logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPORTS - 1);

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> stat == FRAME_CODE);

  // R2
  frame_then_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == SLOT_FRAME) |=> (stat == FRAME_CODE && kind == SLOT_PORT && idx == '0));

  // R2
  port_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == SLOT_PORT && idx != LAST) |=> (kind == SLOT_PORT && idx == $past(idx) + 1'b1));

  // R3
  no_reserved_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == SLOT_PORT) |=> stat != FRAME_CODE);

  // R5 R6
  tail_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == SLOT_PORT && idx == LAST) |=> (kind != SLOT_PORT && ((kind == SLOT_DIP) == $past(dip_en))));

  // R7
  dip_then_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SLOT_DIP) |=> kind == SLOT_FRAME);
endmodule

bind fsc_gen fsc_gen_chk #(.NPORTS(NPORTS), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dip_en(dip_en),
  .stat(stat), .kind(kind), .idx(idx)
);

// File: tb/test_fsc_gen.sv
module test_fsc_gen;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         dip_en = 1'b0;
  logic [2*N-1:0] port_stat = '0;
  logic [1:0]   stat;

  always #5 clk = ~clk;

  fsc_gen #(.NPORTS(N)) i_fsc_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .dip_en(dip_en),
    .port_stat(port_stat), .stat(stat)
  );

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: stat=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] mdl_fold(input logic [1:0] a, input logic [1:0] w);
    return {a[0], a[1]} ^ w;
  endfunction

  task automatic push(input logic [1:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // entered and left just after a rising edge
  task automatic frame(input logic [2*N-1:0] vec, input bit dip, input bit scramble,
                       input int nports, input string ftag);
    logic [1:0] acc;
    logic [1:0] w;
    string      t;
    int         len;
    acc = 2'b00;
    en = 1'b1;
    dip_en = dip;
    port_stat = vec;
    push(2'b11, ftag);
    for (int p = 0; p < nports; p++) begin
      w = vec[2*p +: 2];
      t = scramble ? "R4" : "R2";
      if (w == 2'b11) begin
        w = 2'b10;
        t = "R3";
      end
      push(w, t);
      acc = mdl_fold(acc, w);
    end
    len = 1 + nports;
    if (dip && nports == N) begin
      push(~mdl_fold(acc, 2'b11), "R5");
      len++;
    end
    @(posedge clk); #1;
    if (scramble) port_stat = ~vec;
    repeat (len - 1) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n, input string t);
    en = 1'b0;
    for (int i = 0; i < n; i++) push(2'b11, t);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: one expected word per cycle
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R7: stat=%b expected=<none> queue empty", stat);
      end else begin
        check(tag_q.pop_front(), stat, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R7: watchdog expired, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", stat, 2'b11);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", stat, 2'b11);
    @(posedge clk); #1;
    push(2'b11, "R1");
    mon_on = 1'b1;
    idle(2, "R1");

    frame(20'b00_01_10_00_01_10_00_01_10_00, 1'b1, 1'b0, N, "R2");
    frame(20'b11_00_11_01_10_11_00_01_11_10, 1'b1, 1'b0, N, "R7");
    frame(20'b01_01_01_01_01_01_01_01_01_01, 1'b0, 1'b0, N, "R7");
    frame(20'b10_00_10_00_01_01_10_10_00_01, 1'b0, 1'b0, N, "R6");
    frame(20'b00_10_01_11_00_10_01_11_00_10, 1'b1, 1'b0, N, "R6");
    frame(20'b01_10_00_01_10_00_01_10_00_01, 1'b1, 1'b1, N, "R4");
    frame({N{2'b11}}, 1'b1, 1'b0, N, "R7");
    frame('0, 1'b1, 1'b0, N, "R7");
    frame(20'b10_10_10_10_10_01_01_01_01_01, 1'b1, 1'b0, 4, "R7");
    idle(3, "R8");
    frame(20'b01_00_10_01_00_10_01_00_10_01, 1'b1, 1'b0, N, "R8");
    frame(20'b00_00_01_01_10_10_11_11_00_01, 1'b0, 1'b0, N, "R7");
    idle(2, "R1");

    @(negedge clk); #1;
    mon_on = 1'b0;
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R7: leftover=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule